// File: doc/BRIEF.md
# Majority-Clocked Triple LFSR Keystream Generator

This block produces two serial keystream segments from three linear feedback shift registers of 19, 22 and 23 bits. The registers are clocked irregularly: in every cycle, each one advances only if its clock-control tap agrees with the majority of the three clock-control taps.

A single start pulse captures a 64-bit session key and a 22-bit frame number. The block then runs a fixed schedule with one register step per clock:
- load the key into the three registers;
- mix the frame number into the state over 22 steps;
- run 100 silent steps;
- emit 114 bits for the first direction;
- run 100 more silent steps;
- emit 114 bits for the second direction.

Each keystream bit comes out with a valid strobe and a flag that names the segment it belongs to. A one-cycle done pulse closes the run, and a busy flag covers the whole run.

Top module: `mtk_keystream_gen`

## Requirements
- R1: On an accepted start, `key` bit n (bit n mod 8 of key byte n/8, i.e. the vector bit n) loads in one cycle. Key bits 0..18 go to register A bits 0..18, key bits 19..40 go to register B bits 0..21, and key bits 41..63 go to register C bits 0..22.
- R2: A register step shifts left by one, drops the bit above the register width and puts a feedback bit in bit 0. The feedback bit is the XOR of bits 18, 17, 16 and 13 for A, bits 21, 20, 16 and 12 for B, and bits 22, 21, 18 and 17 for C.
- R3: The clock-control taps are A bit 9, B bit 11 and C bit 11, and all three distinct registers vote. A control value is 0 when two or more taps are 1 and is 1 otherwise. A register steps when the control value XOR its own tap is 1.
- R4: The first 22 steps after the load take frame bits least significant first. Each of these cycles performs the normal clocked step, then XORs the current frame bit into bit 0 of all three registers.
- R5: After mixing, the block runs 100 silent steps, 114 output steps, 100 silent steps and 114 output steps. `ks_valid` is high for exactly 228 cycles per run.
- R6: Each output bit is the XOR of A bit 18, B bit 21 and C bit 22, taken after that cycle's step. `ks_stream` is 0 for the first 114 valid bits and 1 for the second 114, and it is constant within each segment.
- R7: If start is sampled at clock edge 0, the first valid bit is visible after edge 123 and the last after edge 450. `done` is high for exactly one cycle, after edge 451, immediately after the last valid bit.
- R8: `busy` is high from the cycle after the accepted start until `done` rises, and is low whenever `ks_valid` could not be high. A start that arrives while busy is ignored and changes neither the run length nor the output bits.
- R9: A synchronous active-high `rst` clears all registers and counters, returns the block to idle and holds `busy`, `ks_valid`, `ks_stream`, `ks_bit` and `done` low.
- R10: On every stepping cycle, at least two of the three registers advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, accepted only when idle |
| key | input | 64 | Session key, sampled on an accepted start |
| frame | input | 22 | Frame number, sampled on an accepted start |
| ks_bit | output | 1 | Keystream bit, meaningful when ks_valid is high |
| ks_valid | output | 1 | Keystream bit strobe |
| ks_stream | output | 1 | Segment flag: 0 first direction, 1 second |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | Run in progress |

## Verification
A wrong tap, a wrong key slice or a bad majority decision stays hidden for the 122 steps of mixing and warm-up. It then shows in the very first valid bit, 123 cycles after start, and typically corrupts several of the first few bits. A sequencing fault, such as an off-by-one in a phase length, shows as a shift of the first valid bit, a valid count other than 228 or a misplaced done pulse. All of these are compared cycle by cycle against an independent model of the schedule. A start that leaks through mid-run reloads the registers, so every later bit of that run mismatches.

// File: rtl/mtk_pkg.sv
package mtk_pkg;

  localparam int A_W = 19;
  localparam int B_W = 22;
  localparam int C_W = 23;

  localparam int A_FB0 = 18, A_FB1 = 17, A_FB2 = 16, A_FB3 = 13, A_CT = 9;
  localparam int B_FB0 = 21, B_FB1 = 20, B_FB2 = 16, B_FB3 = 12, B_CT = 11;
  localparam int C_FB0 = 22, C_FB1 = 21, C_FB2 = 18, C_FB3 = 17, C_CT = 11;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_MIX,
    PH_WARM_A,
    PH_OUT_A,
    PH_WARM_B,
    PH_OUT_B,
    PH_FIN
  } phase_t;

endpackage

// File: rtl/mtk_lfsr.sv
module mtk_lfsr #(
  parameter int W   = 19,
  parameter int FB0 = 18,
  parameter int FB1 = 17,
  parameter int FB2 = 16,
  parameter int FB3 = 13,
  parameter int CT  = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         advance,
  input  logic         step,
  input  logic         inj,
  output logic         mid,
  output logic         nxt_top
);

  logic [W-1:0] s_q;
  logic [W-1:0] shifted;
  logic [W-1:0] nxt;
  logic         fb;

  always_comb begin
    fb      = s_q[FB0] ^ s_q[FB1] ^ s_q[FB2] ^ s_q[FB3];
    shifted = step ? {s_q[W-2:0], fb} : s_q;
    nxt     = shifted ^ {{(W-1){1'b0}}, inj};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
    end else if (load) begin
      s_q <= seed;
    end else if (advance) begin
      s_q <= nxt;
    end
  end

  assign mid     = s_q[CT];
  assign nxt_top = nxt[W-1];

endmodule

// File: rtl/mtk_clock_vote.sv
module mtk_clock_vote #(
  parameter int N = 3
) (
  input  logic [N-1:0] mid,
  output logic [N-1:0] step_en
);

  localparam int HALF = N / 2;
  localparam int CW   = $clog2(N + 1);

  logic [CW-1:0] ones;
  logic          ctl;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) begin
      ones = ones + CW'(mid[i]);
    end
    ctl     = (ones <= CW'(HALF));
    step_en = {N{ctl}} ^ mid;
  end

endmodule

// File: rtl/mtk_sequencer.sv
module mtk_sequencer
  import mtk_pkg::*;
#(
  parameter int MIX_LEN  = 22,
  parameter int WARM_LEN = 100,
  parameter int OUT_LEN  = 114
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic advance,
  output logic mixing,
  output logic emitting,
  output logic stream_sel,
  output logic finish,
  output logic active
);

  localparam int MAX_A = (MIX_LEN > WARM_LEN) ? MIX_LEN : WARM_LEN;
  localparam int MAX_L = (MAX_A > OUT_LEN) ? MAX_A : OUT_LEN;
  localparam int CNT_W = $clog2(MAX_L + 1);

  phase_t           ph_q;
  phase_t           ph_next;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    unique case (ph_q)
      PH_MIX:              last = CNT_W'(MIX_LEN - 1);
      PH_WARM_A, PH_WARM_B: last = CNT_W'(WARM_LEN - 1);
      default:             last = CNT_W'(OUT_LEN - 1);
    endcase
    unique case (ph_q)
      PH_MIX:    ph_next = PH_WARM_A;
      PH_WARM_A: ph_next = PH_OUT_A;
      PH_OUT_A:  ph_next = PH_WARM_B;
      PH_WARM_B: ph_next = PH_OUT_B;
      PH_OUT_B:  ph_next = PH_FIN;
      default:   ph_next = PH_IDLE;
    endcase
  end

  assign load       = start && (ph_q == PH_IDLE);
  assign advance    = (ph_q != PH_IDLE) && (ph_q != PH_FIN);
  assign mixing     = (ph_q == PH_MIX);
  assign emitting   = (ph_q == PH_OUT_A) || (ph_q == PH_OUT_B);
  assign stream_sel = (ph_q == PH_OUT_B);
  assign finish     = (ph_q == PH_FIN);
  assign active     = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q  <= PH_MIX;
            cnt_q <= '0;
          end
        end
        PH_FIN: ph_q <= PH_IDLE;
        default: begin
          if (cnt_q == last) begin
            cnt_q <= '0;
            ph_q  <= ph_next;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mtk_keystream_gen.sv
module mtk_keystream_gen
  import mtk_pkg::*;
#(
  parameter int FRAME_W  = 22,
  parameter int WARM_LEN = 100,
  parameter int OUT_LEN  = 114
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [A_W+B_W+C_W-1:0]       key,
  input  logic [FRAME_W-1:0]           frame,
  output logic                         ks_bit,
  output logic                         ks_valid,
  output logic                         ks_stream,
  output logic                         done,
  output logic                         busy
);

  localparam int B_LSB = A_W;
  localparam int C_LSB = A_W + B_W;

  logic               load, advance, mixing, emitting, stream_sel, finish;
  logic [2:0]         mid;
  logic [2:0]         step_en;
  logic [2:0]         nxt_top;
  logic [FRAME_W-1:0] frame_q;
  logic               inj;

  mtk_sequencer #(
    .MIX_LEN (FRAME_W),
    .WARM_LEN(WARM_LEN),
    .OUT_LEN (OUT_LEN)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (load),
    .advance   (advance),
    .mixing    (mixing),
    .emitting  (emitting),
    .stream_sel(stream_sel),
    .finish    (finish),
    .active    (busy)
  );

  mtk_clock_vote #(.N(3)) vote_i (
    .mid    (mid),
    .step_en(step_en)
  );

  assign inj = mixing & frame_q[0];

  mtk_lfsr #(.W(A_W), .FB0(A_FB0), .FB1(A_FB1), .FB2(A_FB2), .FB3(A_FB3), .CT(A_CT)) reg_a_i (
    .clk(clk), .rst(rst), .load(load), .seed(key[A_W-1:0]),
    .advance(advance), .step(step_en[0]), .inj(inj),
    .mid(mid[0]), .nxt_top(nxt_top[0])
  );

  mtk_lfsr #(.W(B_W), .FB0(B_FB0), .FB1(B_FB1), .FB2(B_FB2), .FB3(B_FB3), .CT(B_CT)) reg_b_i (
    .clk(clk), .rst(rst), .load(load), .seed(key[B_LSB+B_W-1:B_LSB]),
    .advance(advance), .step(step_en[1]), .inj(inj),
    .mid(mid[1]), .nxt_top(nxt_top[1])
  );

  mtk_lfsr #(.W(C_W), .FB0(C_FB0), .FB1(C_FB1), .FB2(C_FB2), .FB3(C_FB3), .CT(C_CT)) reg_c_i (
    .clk(clk), .rst(rst), .load(load), .seed(key[C_LSB+C_W-1:C_LSB]),
    .advance(advance), .step(step_en[2]), .inj(inj),
    .mid(mid[2]), .nxt_top(nxt_top[2])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (load) begin
      frame_q <= frame;
    end else if (mixing) begin
      frame_q <= frame_q >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit    <= 1'b0;
      ks_valid  <= 1'b0;
      ks_stream <= 1'b0;
      done      <= 1'b0;
    end else begin
      ks_bit    <= emitting & (^nxt_top);
      ks_valid  <= emitting;
      ks_stream <= emitting & stream_sel;
      done      <= finish;
    end
  end

endmodule

// File: rtl/mtk_keystream_chk.sv
module mtk_keystream_chk #(
  parameter int TOTAL = 228
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       ks_valid,
  input logic       ks_stream,
  input logic       done,
  input logic       start,
  input logic       advance,
  input logic [2:0] step_en
);

  localparam int VW = $clog2(TOTAL + 2);

  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      vcnt <= '0;
    end else if (ks_valid) begin
      vcnt <= vcnt + 1'b1;
    end
  end

  p_two_step_r10: assert property (@(posedge clk) disable iff (rst)
    advance |-> ($countones(step_en) >= 2));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_valid_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!ks_valid && $past(ks_valid)));

  p_stream_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ks_valid && $past(ks_valid)) |-> (ks_stream == $past(ks_stream)));

  p_idle_silent_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ks_valid);

  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_valid_total_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (vcnt == VW'(TOTAL)));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !ks_valid && !done));

endmodule

bind mtk_keystream_gen mtk_keystream_chk #(.TOTAL(2 * OUT_LEN)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .ks_valid (ks_valid),
  .ks_stream(ks_stream),
  .done     (done),
  .start    (start),
  .advance  (advance),
  .step_en  (step_en)
);

// File: tb/mtk_keystream_gen_tb_top.sv
`timescale 1ns/1ps
module mtk_keystream_gen_tb_top;

  localparam int NBITS   = 228;
  localparam int FIRST_V = 123;
  localparam int DONE_AT = 451;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] frame = '0;
  logic        ks_bit, ks_valid, ks_stream, done, busy;

  int checks = 0;
  int fails  = 0;
  bit exp_bits [NBITS];

  always #2.5 clk = ~clk;

  mtk_keystream_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .key(key), .frame(frame),
    .ks_bit(ks_bit), .ks_valid(ks_valid), .ks_stream(ks_stream),
    .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model of R1..R6: load, 22 mixing steps, 100/114/100/114.
  task automatic build_ref(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a;
    logic [21:0] b;
    logic [22:0] c;
    int n;
    a = k[18:0];
    b = k[40:19];
    c = k[63:41];
    n = 0;
    for (int i = 0; i < 450; i++) begin
      int  votes;
      bit  ctl, fa, fb, fc;
      votes = int'(a[9]) + int'(b[11]) + int'(c[11]);
      ctl = (votes < 2);
      fa = a[18] ^ a[17] ^ a[16] ^ a[13];
      fb = b[21] ^ b[20] ^ b[16] ^ b[12];
      fc = c[22] ^ c[21] ^ c[18] ^ c[17];
      if (ctl ^ a[9])  a = {a[17:0], fa};
      if (ctl ^ b[11]) b = {b[20:0], fb};
      if (ctl ^ c[11]) c = {c[21:0], fc};
      if (i < 22 && f[i]) begin
        a[0] = ~a[0];
        b[0] = ~b[0];
        c[0] = ~c[0];
      end
      if ((i >= 122 && i < 236) || (i >= 336 && i < 450)) begin
        exp_bits[n] = a[18] ^ b[21] ^ c[22];
        n++;
      end
    end
  endtask

  // Runs one case. If stray_at >= 0, a second start with other inputs is
  // pulsed at that cycle (R8).
  task automatic run_case(input logic [63:0] k, input logic [21:0] f,
                          input int stray_at, input string tag);
    int idx, first_v, done_at, done_cnt, mism;
    bit busy_ok;
    build_ref(k, f);
    @(negedge clk);
    key = k; frame = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0; key = ~k; frame = ~f;
    idx = 0; first_v = -1; done_at = -1; done_cnt = 0; mism = 0; busy_ok = 1;
    for (int c = 0; c < 520; c++) begin
      if (c == stray_at) start = 1'b1;
      if (c == stray_at + 1) start = 1'b0;
      if (ks_valid) begin
        if (first_v < 0) first_v = c;
        if (idx < NBITS) begin
          chk(ks_bit == exp_bits[idx], "R1 R2 R3 R4 R6 R10",
              $sformatf("%s bit %0d", tag, idx), ks_bit, exp_bits[idx]);
          chk(ks_stream == (idx >= 114), "R6",
              $sformatf("%s stream flag at bit %0d", tag, idx), ks_stream, idx >= 114);
          if (ks_bit != exp_bits[idx]) mism++;
        end
        idx++;
      end
      if (c < DONE_AT && !busy) busy_ok = 0;
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = c;
      end
      if (c > DONE_AT + 2) break;
      @(negedge clk);
    end
    chk(idx == NBITS, "R5", {tag, " valid count"}, idx, NBITS);
    chk(first_v == FIRST_V, "R7", {tag, " first valid cycle"}, first_v, FIRST_V);
    chk(done_at == DONE_AT, "R7", {tag, " done cycle"}, done_at, DONE_AT);
    chk(done_cnt == 1, "R7", {tag, " done pulse width"}, done_cnt, 1);
    chk(busy_ok, "R8", {tag, " busy held during run"}, busy_ok, 1);
    chk(!busy, "R8", {tag, " busy low after done"}, busy, 0);
    if (stray_at >= 0)
      chk(mism == 0, "R8", {tag, " stray start ignored"}, mism, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state at the ports
    chk(!busy, "R9", "busy after reset", busy, 0);
    chk(!ks_valid, "R9", "valid after reset", ks_valid, 0);
    chk(!done, "R9", "done after reset", done, 0);
    chk(!ks_bit && !ks_stream, "R9", "bit/stream after reset", ks_bit | ks_stream, 0);

    run_case(64'h0, 22'h0, -1, "zeros");
    run_case({64{1'b1}}, {22{1'b1}}, -1, "ones");
    run_case(64'h0123_4567_89AB_CDEF, 22'h2A5A5, 200, "stray");
    for (int r = 0; r < 4; r++) begin
      run_case({$urandom, $urandom}, 22'($urandom), -1, $sformatf("rand%0d", r));
    end

    // R9: reset in the middle of a run, then a clean run
    @(negedge clk);
    key = 64'hFEDC_BA98_7654_3210; frame = 22'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (140) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy, "R9", "busy after mid-run reset", busy, 0);
    chk(!ks_valid, "R9", "valid after mid-run reset", ks_valid, 0);
    repeat (5) @(negedge clk);
    chk(!ks_valid && !done, "R9", "quiet after mid-run reset", ks_valid | done, 0);
    run_case(64'hFEDC_BA98_7654_3210, 22'h1, -1, "post_reset");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule